// File: doc/BRIEF.md
# Video Controller Register Interface

This block is the host-facing control port of a tile-based video controller. The host writes 16-bit words to a single control port. A word whose top three bits are `100` is a register write: bits 12:8 pick one of 24 eight-bit configuration registers and bits 7:0 give the new value. Any other word is an address command that this block does not interpret. It is handed on unchanged, with a one-cycle strobe, to the unit that owns memory addressing.

From the register contents the block drives decoded configuration to the rest of the controller: display, vertical-interrupt and DMA enables, the 240/224-line select, the scroll modes, the data-port auto-increment and five table base addresses. The interlace mode is staged. A value written to its register is only applied when the next vertical blank begins, so a frame never changes scan structure part-way through.

A control-port read returns a 16-bit status word. It mixes constant bits, live flags from the FIFO, timing and DMA units, and three event flags that stay set until the host reads the status.

Top module: `vidctl_regport`

## Requirements
- R1: A control write with bits 15:13 = `100` and bits 12:8 in 0x00..0x17 stores bits 7:0 in that register. The decoded outputs show the new value in the cycle after the write.
- R2: A `100`-prefixed write with bits 12:8 in 0x18..0x1F changes no output and raises no address-command strobe.
- R3: A control write whose bits 15:13 are not `100` raises `addr_cmd_stb` for exactly the following cycle, with `addr_cmd_word` equal to the written word.
- R4: Register 0x01 decodes as follows: bit 6 drives `disp_en`, bit 5 drives `vint_en`, bit 4 drives `dma_en` and bit 3 drives `tall_mode` (1 selects 240 lines).
- R5: `addr_inc` equals register 0x0F.
- R6: Each table base is a register field moved to the upper address bits, with all lower bits zero:
  - plane A: register 0x02 bits 5:3 become address bits 15:13;
  - plane B: register 0x04 bits 2:0 become bits 15:13;
  - window: register 0x03 bits 5:1 become bits 15:11;
  - sprite: register 0x05 bits 6:0 become bits 15:9;
  - horizontal-scroll table: register 0x0D bits 5:0 become bits 15:10.
- R7: Register 0x0B bit 2 drives `vscroll_col`, and bits 1:0 drive `hscroll_mode`.
- R8: `ilace_mode` takes register 0x0C bits 2:1 only at a clock where `vblank` is 1 and was 0 at the previous clock, using the register value held before that edge. At every other clock it holds its value.
- R9: `stat_rdata` bits 15:10 are `001101`, bit 9 is `fifo_empty` and bit 8 is `fifo_full`.
- R10: `stat_rdata` bits 4:0 are, from bit 4 down: `odd_frame`, `vblank`, `hblank`, `dma_busy`, `pal_sys`. These are the live input values in the same cycle.
- R11: `stat_rdata` bits 7:5 are the sticky vertical-interrupt, sprite-overflow and sprite-collision flags. Each is set by its event input and cleared after a cycle with `ctl_rd` high. An event in the read cycle keeps its flag set.
- R12: After reset all registers, the staged interlace mode, the sticky flags and the address-command strobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_wdata | input | 16 | Control-port write word |
| ctl_rd | input | 1 | Control-port status read strobe |
| stat_rdata | output | 16 | Status word |
| fifo_empty | input | 1 | Data FIFO empty |
| fifo_full | input | 1 | Data FIFO full |
| vint_evt | input | 1 | Vertical interrupt event pulse |
| spr_ovf_evt | input | 1 | Sprite-per-line limit event pulse |
| spr_coll_evt | input | 1 | Sprite collision event pulse |
| odd_frame | input | 1 | Odd interlaced frame |
| vblank | input | 1 | Vertical blank active |
| hblank | input | 1 | Horizontal blank active |
| dma_busy | input | 1 | DMA in progress |
| pal_sys | input | 1 | 50 Hz system |
| disp_en | output | 1 | Display enable |
| vint_en | output | 1 | Vertical interrupt enable |
| dma_en | output | 1 | DMA enable |
| tall_mode | output | 1 | 240-line mode |
| vscroll_col | output | 1 | Per-column vertical scroll |
| hscroll_mode | output | 2 | Horizontal scroll mode |
| ilace_mode | output | 2 | Applied interlace mode |
| addr_inc | output | 8 | Data-port auto-increment |
| plane_a_base | output | 16 | Plane A name table base |
| plane_b_base | output | 16 | Plane B name table base |
| window_base | output | 16 | Window name table base |
| sprite_base | output | 16 | Sprite table base |
| hscroll_base | output | 16 | Horizontal scroll table base |
| addr_cmd_stb | output | 1 | Address command valid |
| addr_cmd_word | output | 16 | Address command word |

## Verification
The hardest situation to reach is a collision of events at one clock edge. One case is a status read in the same cycle as a sticky event. Another is a write to the interlace register at the exact edge where vertical blank rises, where the staged value must come from the old register contents.

The directed sequence lines up both cases explicitly. A long random phase then drives short vblank pulses, dense event pulses and frequent reads and writes. A behavioural model, compared every cycle, catches any other ordering slip.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
    localparam int DATA_W   = 16;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 24;
    localparam int IDX_W    = 5;
    localparam logic [2:0] REG_PREFIX = 3'b100;
    localparam logic [5:0] STAT_FIXED = 6'b001101;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

    localparam int IX_MODE2  = 1;
    localparam int IX_PLANEA = 2;
    localparam int IX_WINDOW = 3;
    localparam int IX_PLANEB = 4;
    localparam int IX_SPRITE = 5;
    localparam int IX_MODE3  = 11;
    localparam int IX_MODE4  = 12;
    localparam int IX_HSCR   = 13;
    localparam int IX_AUTOIN = 15;

    typedef struct packed {
        logic               reg_wr;
        logic [IDX_W-1:0]   idx;
        logic [REG_W-1:0]   val;
        logic               cmd_pass;
        logic [DATA_W-1:0]  word;
    } ctl_dec_t;

    typedef struct packed {
        logic fifo_empty;
        logic fifo_full;
        logic odd_frame;
        logic vblank;
        logic hblank;
        logic dma_busy;
        logic pal_sys;
    } stat_live_t;

    typedef struct packed {
        logic vint;
        logic spr_ovf;
        logic spr_coll;
    } stat_evt_t;

    // Extract a field of width wid starting at bit lo of a register value,
    // then place it with its least significant bit at address bit alsb.
    function automatic logic [DATA_W-1:0] table_base(
        input logic [REG_W-1:0] v, input int lo, input int wid, input int alsb);
        logic [REG_W-1:0] f;
        f = (v >> lo) & REG_W'((1 << wid) - 1);
        return DATA_W'(f) << alsb;
    endfunction
endpackage

// File: rtl/vcr_cmd_decode.sv
module vcr_cmd_decode
    import vcr_pkg::*;
(
    input  logic              wr,
    input  logic [DATA_W-1:0] word,
    output ctl_dec_t          dec
);
    logic is_reg;
    always_comb begin
        is_reg       = (word[15:13] == REG_PREFIX);
        dec.word     = word;
        dec.idx      = word[12:8];
        dec.val      = word[7:0];
        dec.reg_wr   = wr && is_reg && (word[12:8] <= LAST_IDX);
        dec.cmd_pass = wr && !is_reg;
    end
endmodule

// File: rtl/vcr_regfile.sv
module vcr_regfile
    import vcr_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int W  = REG_W,
    parameter int IW = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [IW-1:0]        idx,
    input  logic [W-1:0]         val,
    output logic [N-1:0][W-1:0]  regs
);
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && idx == IW'(g))
                regs[g] <= val;
        end
    end

    AST_REG_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(idx)] == $past(val)); // R1
endmodule

// File: rtl/vcr_ilace_stage.sv
module vcr_ilace_stage (
    input  logic       clk,
    input  logic       rst,
    input  logic       vblank,
    input  logic [1:0] pending,
    output logic [1:0] active
);
    logic vb_q;
    logic vb_rise;

    always_comb vb_rise = vblank && !vb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vb_q   <= 1'b0;
            active <= 2'b00;
        end else begin
            vb_q <= vblank;
            if (vb_rise)
                active <= pending;
        end
    end

    AST_ILACE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !vb_rise |=> $stable(active)); // R8
    AST_ILACE_APPLY: assert property (@(posedge clk) disable iff (rst)
        vb_rise |=> active == $past(pending)); // R8
endmodule

// File: rtl/vcr_status.sv
module vcr_status
    import vcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  stat_evt_t         evt,
    input  stat_live_t        live,
    output logic [DATA_W-1:0] stat
);
    stat_evt_t flags;

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= evt | (rd ? stat_evt_t'('0) : flags);
    end

    always_comb begin
        stat = {STAT_FIXED, live.fifo_empty, live.fifo_full,
                flags.vint, flags.spr_ovf, flags.spr_coll,
                live.odd_frame, live.vblank, live.hblank,
                live.dma_busy, live.pal_sys};
    end

    AST_VINT_STICKY: assert property (@(posedge clk) disable iff (rst)
        evt.vint |=> stat[7]); // R11
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd && !evt.vint && !evt.spr_ovf && !evt.spr_coll) |=> stat[7:5] == 3'b000); // R11
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!rd && stat[6]) |=> stat[6]); // R11
endmodule

// File: rtl/vidctl_regport.sv
module vidctl_regport
    import vcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        ctl_rd,
    output logic [15:0] stat_rdata,
    input  logic        fifo_empty,
    input  logic        fifo_full,
    input  logic        vint_evt,
    input  logic        spr_ovf_evt,
    input  logic        spr_coll_evt,
    input  logic        odd_frame,
    input  logic        vblank,
    input  logic        hblank,
    input  logic        dma_busy,
    input  logic        pal_sys,
    output logic        disp_en,
    output logic        vint_en,
    output logic        dma_en,
    output logic        tall_mode,
    output logic        vscroll_col,
    output logic [1:0]  hscroll_mode,
    output logic [1:0]  ilace_mode,
    output logic [7:0]  addr_inc,
    output logic [15:0] plane_a_base,
    output logic [15:0] plane_b_base,
    output logic [15:0] window_base,
    output logic [15:0] sprite_base,
    output logic [15:0] hscroll_base,
    output logic        addr_cmd_stb,
    output logic [15:0] addr_cmd_word
);
    ctl_dec_t                          dec;
    logic [NUM_REGS-1:0][REG_W-1:0]    regs;
    stat_evt_t                         evt;
    stat_live_t                        live;

    vcr_cmd_decode u_dec (
        .wr   (ctl_wr),
        .word (ctl_wdata),
        .dec  (dec)
    );

    vcr_regfile #(.N(NUM_REGS), .W(REG_W), .IW(IDX_W)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (dec.reg_wr),
        .idx  (dec.idx),
        .val  (dec.val),
        .regs (regs)
    );

    vcr_ilace_stage u_ilace (
        .clk     (clk),
        .rst     (rst),
        .vblank  (vblank),
        .pending (regs[IX_MODE4][2:1]),
        .active  (ilace_mode)
    );

    always_comb begin
        evt  = '{vint: vint_evt, spr_ovf: spr_ovf_evt, spr_coll: spr_coll_evt};
        live = '{fifo_empty: fifo_empty, fifo_full: fifo_full, odd_frame: odd_frame,
                 vblank: vblank, hblank: hblank, dma_busy: dma_busy, pal_sys: pal_sys};
    end

    vcr_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .rd   (ctl_rd),
        .evt  (evt),
        .live (live),
        .stat (stat_rdata)
    );

    // Decoded configuration fields
    always_comb begin
        disp_en      = regs[IX_MODE2][6];
        vint_en      = regs[IX_MODE2][5];
        dma_en       = regs[IX_MODE2][4];
        tall_mode    = regs[IX_MODE2][3];
        vscroll_col  = regs[IX_MODE3][2];
        hscroll_mode = regs[IX_MODE3][1:0];
        addr_inc     = regs[IX_AUTOIN];
        plane_a_base = table_base(regs[IX_PLANEA], 3, 3, 13);
        plane_b_base = table_base(regs[IX_PLANEB], 0, 3, 13);
        window_base  = table_base(regs[IX_WINDOW], 1, 5, 11);
        sprite_base  = table_base(regs[IX_SPRITE], 0, 7, 9);
        hscroll_base = table_base(regs[IX_HSCR],   0, 6, 10);
    end

    // Address-command pass-through
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_cmd_stb  <= 1'b0;
            addr_cmd_word <= '0;
        end else begin
            addr_cmd_stb <= dec.cmd_pass;
            if (dec.cmd_pass)
                addr_cmd_word <= dec.word;
        end
    end

    AST_PASS_STROBE: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[15:13] != 3'b100) |=> addr_cmd_stb && addr_cmd_word == $past(ctl_wdata)); // R3
    AST_STROBE_ONLY_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr && ctl_wdata[15:13] != 3'b100) |=> !addr_cmd_stb); // R3
    AST_HIGH_REG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[15:13] == 3'b100 && ctl_wdata[12:8] > 5'h17)
        |=> $stable(addr_inc) && $stable(plane_a_base) && $stable(disp_en) && !addr_cmd_stb); // R2
    AST_AUTOINC_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[15:8] == 8'h8F) |=> addr_inc == $past(ctl_wdata[7:0])); // R5
endmodule

// File: tb/vidctl_regport_bench.sv
module vidctl_regport_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr = 1'b0, rd = 1'b0;
    logic [15:0] wd = '0;
    logic fe = 0, ff = 0, vip = 0, sop = 0, scp = 0;
    logic odd = 0, vb = 0, hb = 0, dma = 0, pal = 0;

    logic [15:0] stat, a_base, b_base, w_base, s_base, h_base, cmd_word;
    logic disp, vint, dmae, tall, vcol, stb;
    logic [1:0] hmode, ilace;
    logic [7:0] inc;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    vidctl_regport u_vidctl_regport (
        .clk(clk), .rst(rst), .ctl_wr(wr), .ctl_wdata(wd), .ctl_rd(rd),
        .stat_rdata(stat), .fifo_empty(fe), .fifo_full(ff),
        .vint_evt(vip), .spr_ovf_evt(sop), .spr_coll_evt(scp),
        .odd_frame(odd), .vblank(vb), .hblank(hb), .dma_busy(dma), .pal_sys(pal),
        .disp_en(disp), .vint_en(vint), .dma_en(dmae), .tall_mode(tall),
        .vscroll_col(vcol), .hscroll_mode(hmode), .ilace_mode(ilace),
        .addr_inc(inc), .plane_a_base(a_base), .plane_b_base(b_base),
        .window_base(w_base), .sprite_base(s_base), .hscroll_base(h_base),
        .addr_cmd_stb(stb), .addr_cmd_word(cmd_word)
    );

    // Behavioural reference model
    int m_reg [24];
    int m_vi, m_so, m_sc, m_il, m_vbq, m_stb, m_word;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_reg[i]) m_reg[i] = 0;
            m_vi = 0; m_so = 0; m_sc = 0; m_il = 0; m_vbq = 0; m_stb = 0; m_word = 0;
        end else begin
            if (vb && m_vbq == 0) m_il = (m_reg[12] / 2) % 4;
            m_vbq = vb;
            m_vi = vip ? 1 : (rd ? 0 : m_vi);
            m_so = sop ? 1 : (rd ? 0 : m_so);
            m_sc = scp ? 1 : (rd ? 0 : m_sc);
            m_stb = 0;
            if (wr) begin
                if (wd[15:13] == 3'd4) begin
                    if (int'(wd[12:8]) < 24) m_reg[wd[12:8]] = int'(wd[7:0]);
                end else begin
                    m_stb = 1;
                    m_word = int'(wd);
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int fld(input int v, input int lo, input int wid, input int alsb);
        return ((v >> lo) % (1 << wid)) * (1 << alsb);
    endfunction

    task automatic compare_all();
        int st;
        st = 16'h3400 + (int'(fe) << 9) + (int'(ff) << 8) + (m_vi << 7) + (m_so << 6)
           + (m_sc << 5) + (int'(odd) << 4) + (int'(vb) << 3) + (int'(hb) << 2)
           + (int'(dma) << 1) + int'(pal);
        chk("R4 disp_en",   int'(disp), (m_reg[1] >> 6) % 2);
        chk("R4 vint_en",   int'(vint), (m_reg[1] >> 5) % 2);
        chk("R4 dma_en",    int'(dmae), (m_reg[1] >> 4) % 2);
        chk("R4 tall_mode", int'(tall), (m_reg[1] >> 3) % 2);
        chk("R5 addr_inc",  int'(inc),  m_reg[15]);
        chk("R6 plane A",   int'(a_base), fld(m_reg[2], 3, 3, 13));
        chk("R6 plane B",   int'(b_base), fld(m_reg[4], 0, 3, 13));
        chk("R6 window",    int'(w_base), fld(m_reg[3], 1, 5, 11));
        chk("R6 sprite",    int'(s_base), fld(m_reg[5], 0, 7, 9));
        chk("R6 hscroll",   int'(h_base), fld(m_reg[13], 0, 6, 10));
        chk("R7 vscroll",   int'(vcol), (m_reg[11] >> 2) % 2);
        chk("R7 hscroll",   int'(hmode), m_reg[11] % 4);
        chk("R8 ilace",     int'(ilace), m_il);
        chk("R9 stat hi",   int'(stat[15:8]), st >> 8);
        chk("R11 sticky",   int'(stat[7:5]), (st >> 5) % 8);
        chk("R10 live",     int'(stat[4:0]), st % 32);
        chk("R3 strobe",    int'(stb), m_stb);
        if (m_stb == 1) chk("R3 word", int'(cmd_word), m_word);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wreg(input logic [15:0] w);
        wr = 1; wd = w; tick(); wr = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12: reset state
        chk("R12 addr_inc", int'(inc), 0);
        chk("R12 ilace", int'(ilace), 0);
        chk("R12 sticky", int'(stat[7:5]), 0);
        chk("R12 strobe", int'(stb), 0);
        chk("R12 plane A", int'(a_base), 0);
        tick();

        // R1 / R5: auto-increment register 0x0F
        wreg(16'h8F02);
        chk("R1 write lands", int'(inc), 2);
        // R4: mode register 0x01
        wreg(16'h8178);
        chk("R4 all four", {disp, vint, dmae, tall}, 4'b1111);
        wreg(16'h8140);
        chk("R4 display only", {disp, vint, dmae, tall}, 4'b1000);
        // R6: table bases
        wreg(16'h8238); chk("R6 plane A max", int'(a_base), 16'hE000);
        wreg(16'h82C7); chk("R6 plane A masked", int'(a_base), 0);
        wreg(16'h857F); chk("R6 sprite", int'(s_base), 16'hFE00);
        wreg(16'h8407); chk("R6 plane B", int'(b_base), 16'hE000);
        wreg(16'h833E); chk("R6 window", int'(w_base), 16'hF800);
        wreg(16'h8D3F); chk("R6 hscroll", int'(h_base), 16'hFC00);
        // R7
        wreg(16'h8B07); chk("R7 modes", {vcol, hmode}, 3'b111);
        // R2: out-of-range register numbers
        wreg(16'h9822);
        chk("R2 no strobe", int'(stb), 0);
        chk("R2 inc kept", int'(inc), 2);
        wreg(16'h9FFF);
        chk("R2 plane A kept", int'(a_base), 0);
        chk("R2 disp kept", int'(disp), 1);
        // R3: pass-through commands
        wreg(16'h4123);
        chk("R3 strobe", int'(stb), 1);
        chk("R3 word", int'(cmd_word), 16'h4123);
        tick();
        chk("R3 one cycle", int'(stb), 0);
        wreg(16'hA000);
        chk("R3 prefix 101", int'(cmd_word), 16'hA000);

        // R8: interlace staged to vblank rise
        vb = 1; tick(); vb = 0; tick();
        wreg(16'h8C06);
        chk("R8 not yet", int'(ilace), 0);
        tick(); tick();
        chk("R8 still waiting", int'(ilace), 0);
        vb = 1; wr = 1; wd = 16'h8C02; tick(); wr = 0;
        chk("R8 old value at rise", int'(ilace), 3);
        tick();
        chk("R8 held in blank", int'(ilace), 3);
        vb = 0; tick(); vb = 1; tick();
        chk("R8 next rise", int'(ilace), 1);
        vb = 0;

        // R9 / R10: status layout with live inputs
        fe = 1; ff = 0; odd = 1; vb = 0; hb = 1; dma = 0; pal = 1; tick();
        chk("R9 high byte", int'(stat[15:8]), 16'h36);
        chk("R10 live bits", int'(stat[4:0]), 5'b10101);
        fe = 0; ff = 1; odd = 0; hb = 0; dma = 1; pal = 0; tick();
        chk("R9 full", int'(stat[15:8]), 16'h35);
        chk("R10 dma", int'(stat[4:0]), 5'b00010);
        ff = 0; dma = 0;

        // R11: sticky flags
        vip = 1; tick(); vip = 0;
        chk("R11 vint set", int'(stat[7]), 1);
        tick(); chk("R11 vint held", int'(stat[7]), 1);
        rd = 1; tick(); rd = 0;
        chk("R11 cleared by read", int'(stat[7:5]), 0);
        sop = 1; scp = 1; tick(); sop = 0; scp = 0;
        chk("R11 sprite flags", int'(stat[6:5]), 2'b11);
        rd = 1; sop = 1; tick(); rd = 0; sop = 0;
        chk("R11 event wins read", int'(stat[6:5]), 2'b10);

        // Random phase against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r  = $urandom_range(0, 99);
            wr = (r < 40);
            case ($urandom_range(0, 3))
                0: wd = {3'b100, 5'($urandom_range(0, 31)), 8'($urandom)};
                1: wd = {3'b100, 5'($urandom_range(0, 15)), 8'($urandom)};
                2: wd = {3'b100, 5'd12, 8'($urandom)};
                default: wd = 16'($urandom);
            endcase
            rd  = ($urandom_range(0, 3) == 0);
            vip = ($urandom_range(0, 9) == 0);
            sop = ($urandom_range(0, 9) == 0);
            scp = ($urandom_range(0, 9) == 0);
            vb  = ($urandom_range(0, 5) == 0);
            {fe, ff, odd, hb, dma, pal} = 6'($urandom);
            tick();
        end
        wr = 0; rd = 0;
        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule